// File: doc/BRIEF.md
# Flash Status Register Protection Unit

This block keeps the protection bits of a serial flash device's status register: one protect/lock bit and a three-bit block-protect code. It decides whether a request to rewrite those bits is honoured and, for every program or erase target, whether the target is protected. The memory array is 256 KB, split into 64 sectors of 4 KB, plus one separate security sector.

The protect/lock bit has two roles. In normal mode it locks the status register against rewrites whenever the active-low write-protect pin is held low. In one-time-programmable (OTP) mode it becomes a one-shot lock on the security sector. In that mode a status write ignores its data byte, sets the bit, and the bit can never be cleared again until reset. A write-enable latch must be armed before any status write is considered. Every status write request drops the latch.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset `stat_o` is 4'b0000, and `wel_o`, `wrsr_ack_o` and `wrsr_rej_o` are 0.
- R2: A `wren_set_i` pulse sets `wel_o` in the next cycle. Any `wrsr_req_i` clears it in the next cycle; a request wins over a set in the same cycle. A request made while `wel_o` is 0 is rejected and changes no bit.
- R3: The outcome of a request shows one cycle after it as a one-cycle pulse: `wrsr_ack_o` when accepted, `wrsr_rej_o` when rejected, never both. The bits update in the same cycle. `stat_o[3]` is the lock bit and `stat_o[2:0]` is the block-protect code.
- R4: In normal mode an accepted write loads the lock bit from data bit 7 and the block-protect code from data bits 4:2. All other data bits are ignored.
- R5: In normal mode, a request is rejected and changes no bit while the lock bit is 1 and `wp_ni` is 0.
- R6: In normal mode, a request whose data bits 4:2 hold a reserved code (001, 010 or 011) is rejected.
- R7: In OTP mode, a request ignores its data byte and `wp_ni`. If the lock bit is 0 it sets the bit to 1, leaves the block-protect code unchanged, and is accepted. If the lock bit is already 1 it is rejected.
- R8: Once the lock bit has been set in OTP mode, it stays 1 until reset, even through later accepted normal-mode writes with data bit 7 at 0.
- R9: Array protection by code: 000 protects nothing; 100 protects sectors 0 to 47 (below 30000h); 101 protects sectors 0 to 31 (below 20000h); 110 and 111 protect the whole array; reserved codes protect nothing.
- R10: `addr_prot_o` is combinational and is 0 while `pe_req_i` is 0. With `sec_sel_i` at 1, the target is the security sector. That target is protected only after the OTP-mode lock of R8 has been set; the array code does not apply to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_ni | input | 1 | Write-protect pin, active low |
| otp_mode_i | input | 1 | OTP mode selected |
| wren_set_i | input | 1 | Arm the write-enable latch |
| wrsr_req_i | input | 1 | Status write request, one cycle |
| wrsr_data_i | input | 8 | Status write data byte |
| pe_req_i | input | 1 | Program/erase check request |
| sec_sel_i | input | 1 | Target is the security sector |
| addr_i | input | 18 | Program/erase byte address |
| stat_o | output | 4 | {lock bit, block-protect code} |
| wel_o | output | 1 | Write-enable latch |
| wrsr_ack_o | output | 1 | Status write accepted (pulse) |
| wrsr_rej_o | output | 1 | Status write rejected (pulse) |
| addr_prot_o | output | 1 | Target address is protected |

## Verification
A table of status writes walks the gate through four kinds of request. Accepted normal writes show that the data fields are loaded. Requests without the latch show the latch is required. Reserved codes and pin-locked requests show the normal-mode rejections. OTP writes with junk data show the data byte is ignored and the lock is set only once. Address probes sit on each side of the 30000h and 20000h boundaries and at the array top under every code, so an off-by-one sector limit or a swapped code is caught. The security sector is probed before and after the OTP lock, and again after a later normal write tries to clear the bit.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    typedef struct packed {
        logic       lock;
        logic [2:0] bp;
    } sr_bits_t;

    typedef struct packed {
        sr_bits_t sr;
        logic     otp_lock;
        logic     wel;
        logic     ack;
        logic     rej;
    } guard_regs_t;

    localparam logic [2:0] BP_NONE  = 3'b000;
    localparam logic [2:0] BP_LOW_A = 3'b100;
    localparam logic [2:0] BP_LOW_B = 3'b101;
    localparam logic [2:0] BP_ALL_X = 3'b110;
    localparam logic [2:0] BP_ALL   = 3'b111;

    function automatic logic bp_reserved(input logic [2:0] code);
        return (code != BP_NONE) && (code[2] == 1'b0);
    endfunction

endpackage

// File: rtl/flash_prot_map.sv
module flash_prot_map
    import flash_sr_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int SECT_BITS  = 12,
    parameter int LOW_A_SECT = 48,
    parameter int LOW_B_SECT = 32
) (
    input  logic [2:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sec_sel_i,
    input  logic              sec_locked_i,
    input  logic              pe_req_i,
    output logic              prot_o
);
    localparam int IDX_W = ADDR_W - SECT_BITS;

    logic [IDX_W-1:0] sect_idx;
    logic             array_hit;

    assign sect_idx = addr_i[ADDR_W-1:SECT_BITS];

    always_comb begin
        unique case (bp_i)
            BP_LOW_A: array_hit = (int'(sect_idx) < LOW_A_SECT);
            BP_LOW_B: array_hit = (int'(sect_idx) < LOW_B_SECT);
            BP_ALL_X,
            BP_ALL:   array_hit = 1'b1;
            default:  array_hit = 1'b0;
        endcase
    end

    assign prot_o = pe_req_i & (sec_sel_i ? sec_locked_i : array_hit);

    // R10: no protection report without a request
    always_comb begin
        a_r10_idle_clear: assert (pe_req_i || !prot_o);
    end
endmodule

// File: rtl/flash_wrsr_gate.sv
module flash_wrsr_gate
    import flash_sr_pkg::*;
(
    input  logic       wel_i,
    input  logic       otp_mode_i,
    input  logic       wp_ni,
    input  logic       lock_i,
    input  logic [2:0] new_bp_i,
    output logic       accept_o
);
    logic hw_locked;
    logic normal_ok;
    logic otp_ok;

    assign hw_locked = lock_i & ~wp_ni;
    assign normal_ok = ~hw_locked & ~bp_reserved(new_bp_i);
    assign otp_ok    = ~lock_i;
    assign accept_o  = wel_i & (otp_mode_i ? otp_ok : normal_ok);
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
    import flash_sr_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int SECT_BITS  = 12,
    parameter int LOW_A_SECT = 48,
    parameter int LOW_B_SECT = 32,
    parameter int DATA_W     = 8,
    parameter int LOCK_POS   = 7,
    parameter int BP_LSB     = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wp_ni,
    input  logic              otp_mode_i,
    input  logic              wren_set_i,
    input  logic              wrsr_req_i,
    input  logic [DATA_W-1:0] wrsr_data_i,
    input  logic              pe_req_i,
    input  logic              sec_sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [3:0]        stat_o,
    output logic              wel_o,
    output logic              wrsr_ack_o,
    output logic              wrsr_rej_o,
    output logic              addr_prot_o
);
    localparam int BP_MSB = BP_LSB + 2;

    guard_regs_t q, d;
    logic        accept;
    logic [2:0]  new_bp;

    assign new_bp = wrsr_data_i[BP_MSB:BP_LSB];

    flash_wrsr_gate u_gate (
        .wel_i      (q.wel),
        .otp_mode_i (otp_mode_i),
        .wp_ni      (wp_ni),
        .lock_i     (q.sr.lock),
        .new_bp_i   (new_bp),
        .accept_o   (accept)
    );

    flash_prot_map #(
        .ADDR_W     (ADDR_W),
        .SECT_BITS  (SECT_BITS),
        .LOW_A_SECT (LOW_A_SECT),
        .LOW_B_SECT (LOW_B_SECT)
    ) u_map (
        .bp_i         (q.sr.bp),
        .addr_i       (addr_i),
        .sec_sel_i    (sec_sel_i),
        .sec_locked_i (q.otp_lock),
        .pe_req_i     (pe_req_i),
        .prot_o       (addr_prot_o)
    );

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        d.rej = 1'b0;
        if (wren_set_i) begin
            d.wel = 1'b1;
        end
        if (wrsr_req_i) begin
            d.wel = 1'b0;
            if (accept) begin
                d.ack = 1'b1;
                if (otp_mode_i) begin
                    d.sr.lock  = 1'b1;
                    d.otp_lock = 1'b1;
                end else begin
                    d.sr.lock = wrsr_data_i[LOCK_POS] | q.otp_lock;
                    d.sr.bp   = new_bp;
                end
            end else begin
                d.rej = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign stat_o     = q.sr;
    assign wel_o      = q.wel;
    assign wrsr_ack_o = q.ack;
    assign wrsr_rej_o = q.rej;

    // R2: every request drops the latch
    a_r2_wel_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrsr_req_i |=> !wel_o);

    // R2: request without latch is refused and leaves bits alone
    a_r2_need_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrsr_req_i && !wel_o) |=> (wrsr_rej_o && $stable(stat_o)));

    // R3: outcome flags are exclusive
    a_r3_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wrsr_ack_o && wrsr_rej_o));

    // R3: an outcome only follows a request
    a_r3_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrsr_req_i |=> !(wrsr_ack_o || wrsr_rej_o));

    // R5: pin-held lock freezes the bits in normal mode
    a_r5_hw_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrsr_req_i && !otp_mode_i && stat_o[3] && !wp_ni)
            |=> (wrsr_rej_o && $stable(stat_o)));

    // R6: a reserved code is never stored
    a_r6_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bp_reserved(stat_o[2:0]));

    // R7: OTP write keeps the protect code and sets the lock
    a_r7_otp_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrsr_req_i && otp_mode_i && wel_o && !stat_o[3])
            |=> (wrsr_ack_o && stat_o[3] && stat_o[2:0] == $past(stat_o[2:0])));

    // R8: the one-time lock never falls
    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.otp_lock |=> (q.otp_lock && stat_o[3]));
endmodule

// File: tb/flash_sr_guard_tb.sv
module flash_sr_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_n = 1'b1;
    logic        otp = 1'b0;
    logic        wren = 1'b0;
    logic        req = 1'b0;
    logic [7:0]  data = 8'h00;
    logic        pe = 1'b0;
    logic        sec = 1'b0;
    logic [17:0] addr = '0;
    logic [3:0]  stat;
    logic        wel, ack, rej, prot;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_sr_guard u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_n), .otp_mode_i(otp),
        .wren_set_i(wren), .wrsr_req_i(req), .wrsr_data_i(data),
        .pe_req_i(pe), .sec_sel_i(sec), .addr_i(addr),
        .stat_o(stat), .wel_o(wel), .wrsr_ack_o(ack), .wrsr_rej_o(rej),
        .addr_prot_o(prot)
    );

    // vector: [15] arm latch, [14] otp, [13] wp_n, [12:5] data, [4] expect ack, [3:0] expect stat
    localparam int NV = 10;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b1, 8'h10, 1'b1, 4'b0100},
        {1'b0, 1'b0, 1'b1, 8'h1C, 1'b0, 4'b0100},
        {1'b1, 1'b0, 1'b1, 8'h04, 1'b0, 4'b0100},
        {1'b1, 1'b0, 1'b1, 8'h94, 1'b1, 4'b1101},
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'b1101},
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 4'b0000},
        {1'b1, 1'b1, 1'b0, 8'h1C, 1'b1, 4'b1000},
        {1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 4'b1000},
        {1'b1, 1'b0, 1'b1, 8'h18, 1'b1, 4'b1110},
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'b1110}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // arm (optional), issue one request, sample outcome one cycle later
    task automatic wr(input logic arm, input logic o, input logic w, input logic [7:0] dat);
        if (arm) begin
            wren = 1'b1;
            @(negedge clk);
            wren = 1'b0;
        end
        otp = o; wp_n = w; data = dat; req = 1'b1;
        @(negedge clk);
        req = 1'b0; otp = 1'b0; wp_n = 1'b1;
    endtask

    task automatic probe(input string tag, input logic s, input logic [17:0] a, input logic exp);
        pe = 1'b1; sec = s; addr = a;
        #1;
        chk(tag, {7'd0, prot}, {7'd0, exp});
        pe = 1'b0; sec = 1'b0;
    endtask

    initial begin
        do_reset();
        chk("R1 stat", {4'd0, stat}, 8'h00);
        chk("R1 flags", {5'd0, wel, ack, rej}, 8'h00);

        // R2 latch set and clear
        wren = 1'b1; @(negedge clk); wren = 1'b0;
        chk("R2 wel set", {7'd0, wel}, 8'h01);
        wren = 1'b1; req = 1'b1; data = 8'h10; @(negedge clk);
        wren = 1'b0; req = 1'b0;
        chk("R2 req wins", {7'd0, wel}, 8'h00);
        chk("R3 ack pulse", {6'd0, ack, rej}, 8'h02);
        @(negedge clk);
        chk("R3 pulse ends", {6'd0, ack, rej}, 8'h00);

        // R9 array map under each code (currently 100)
        probe("R9 100 top of range", 1'b0, 18'h2FFFF, 1'b1);
        probe("R9 100 above range", 1'b0, 18'h30000, 1'b0);
        probe("R10 sec open", 1'b1, 18'h00000, 1'b0);
        wr(1'b1, 1'b0, 1'b1, 8'h14);
        probe("R9 101 top of range", 1'b0, 18'h1FFFF, 1'b1);
        probe("R9 101 above range", 1'b0, 18'h20000, 1'b0);
        wr(1'b1, 1'b0, 1'b1, 8'h18);
        probe("R9 110 array top", 1'b0, 18'h3FFFF, 1'b1);
        wr(1'b1, 1'b0, 1'b1, 8'h1C);
        probe("R9 111 base", 1'b0, 18'h00000, 1'b1);
        pe = 1'b0; addr = 18'h00000; #1;
        chk("R10 idle", {7'd0, prot}, 8'h00);
        wr(1'b1, 1'b0, 1'b1, 8'h63);
        chk("R4 ignored bits", {4'd0, stat}, 8'h00);
        probe("R9 000 none", 1'b0, 18'h00000, 1'b0);

        // table of status writes from a clean state
        do_reset();
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12:5]);
            chk($sformatf("R3-R7 vec%0d outcome", i), {6'd0, ack, rej},
                {6'd0, VEC[i][4], ~VEC[i][4]});
            chk($sformatf("R4-R8 vec%0d stat", i), {4'd0, stat}, {4'd0, VEC[i][3:0]});
        end
        probe("R10 sec locked", 1'b1, 18'h00000, 1'b1);
        probe("R8 lock stays, array 110", 1'b0, 18'h3FFFF, 1'b1);
        wr(1'b1, 1'b0, 1'b1, 8'h00);
        chk("R8 sticky after clear try", {4'd0, stat}, 8'h08);
        probe("R10 sec still locked", 1'b1, 18'h00000, 1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule